// File: doc/BRIEF.md
# Decoded I/O Port with Output Latches

This block sits on the peripheral side of a 16-bit processor bus and gives the processor eight I/O port numbers in a small window of the 64K I/O space. From the bus read, write and memory/IO signals it forms separate I/O-read and I/O-write strobes. Memory cycles never reach the ports. The I/O address is checked against a fixed pattern and a parameterised upper byte. A 3-to-8 decoder with one active-high enable and two active-low enables then turns the three low address bits into a one-hot port select.

Each port number serves two devices: an output latch and an input. A write cycle stores the data into the latch, which holds it long after the bus pulse has ended. A read cycle returns the matching external input word. The read data goes back through per-lane drive enables, which are the control for the bus tri-state buffers. The enables are active only during a decoded I/O read. The byte-high-enable (active low) and address bit 0 choose which byte lanes take part in a cycle.

Top module: `ioDecodedPort`

## Requirements
- R1: A cycle is an I/O cycle only when `memIoN` is 0. With `memIoN` = 1, no output latch changes and `rdOe` stays 0.
- R2: A port responds only when `addr[15:8]` equals parameter `HI_MATCH` (default 8'h00) and `addr[7:3]` equals 5'b11110. This gives the window 00F0h–00F7h. Any other address leaves the latches unchanged and `rdOe` at 0.
- R3: Inside the window, `addr[2:0]` selects exactly one port, numbered 0 to 7. Port k occupies bits [16k+15:16k] of `portOut` and `portIn`.
- R4: When `wrN` = 0 and `memIoN` = 0 to a hit address, the selected latch loads `dataIn` on each rising clock edge. The latch keeps its value after `wrN` returns to 1, until the next write or reset.
- R5: Byte lanes follow {`bheN`, `addr[0]`]}. 00 selects both lanes (bits 15:0). 01 selects only the high lane (bits 15:8). 10 selects only the low lane (bits 7:0). 11 is illegal: nothing is written and nothing is driven.
- R6: `rdOe` lane bits are 1 only while `rdN` = 0 and `memIoN` = 0 at a hit address, for the lanes that R5 selects. `rdData` then carries the selected port's `portIn` word. `rdData` is 0 when `rdOe` is 0.
- R7: A read of a port number returns that port's external input, not its latch contents. A read never changes any latch.
- R8: An active-low reset clears all eight output latches to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdN | input | 1 | Read command, active low |
| wrN | input | 1 | Write command, active low |
| memIoN | input | 1 | 1 = memory space, 0 = I/O space |
| addr | input | 16 | I/O address from the bus |
| bheN | input | 1 | Byte-high enable, active low |
| dataIn | input | 16 | Write data from the bus |
| rdData | output | 16 | Read data toward the bus buffers |
| rdOe | output | 2 | Drive enable per byte lane (bit 1 = high lane) |
| portIn | input | 128 | External input words of the eight ports |
| portOut | output | 128 | Held output words of the eight ports |

## Verification
A bad latch select or a bad lane enable shows on `portOut` one clock after the write edge. The wrong port or byte then changes, or the intended one does not. The bench compares all eight latches against its own model after every cycle it drives. A decode or strobe fault that drives the bus when it should not shows on `rdOe` in the same cycle, combinationally. The bench therefore samples `rdOe` and `rdData` within the cycle of each read, miss, memory access and illegal lane pattern.

// File: rtl/ioPortPkg.sv
package ioPortPkg;
  localparam int BYTE_W    = 8;
  localparam int LANES     = 2;
  localparam int WORD_W    = BYTE_W * LANES;
  localparam int SEL_W     = 3;
  localparam int NUM_PORTS = 1 << SEL_W;

  // strobes handed from control to datapath
  typedef struct packed {
    logic                 ioRd;
    logic                 ioWr;
    logic [NUM_PORTS-1:0] portSel;
    logic [LANES-1:0]     laneEn;
  } portStrobeT;
endpackage

// File: rtl/ioSelDecoder.sv
module ioSelDecoder #(
  parameter int SEL_W = 3,
  localparam int OUTS = 1 << SEL_W
) (
  input  logic             g1,
  input  logic             g2aN,
  input  logic             g2bN,
  input  logic [SEL_W-1:0] sel,
  output logic [OUTS-1:0]  lineOut
);
  logic enabled;
  assign enabled = g1 & ~g2aN & ~g2bN;

  for (genvar i = 0; i < OUTS; i++) begin : g_line
    assign lineOut[i] = enabled && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/ioPortCtrl.sv
module ioPortCtrl
  import ioPortPkg::*;
#(
  parameter logic [7:0] HI_MATCH = 8'h00
) (
  input  logic        rdN,
  input  logic        wrN,
  input  logic        memIoN,
  input  logic [15:0] addr,
  input  logic        bheN,
  output portStrobeT  strobes
);
  logic ioRd, ioWr, pageHit, groupHit;
  logic [NUM_PORTS-1:0] lines;

  assign ioRd     = ~rdN & ~memIoN;
  assign ioWr     = ~wrN & ~memIoN;
  assign pageHit  = (addr[15:8] == HI_MATCH);
  assign groupHit = &addr[7:4];

  ioSelDecoder #(.SEL_W(SEL_W)) i_dec (
    .g1     (pageHit & groupHit),
    .g2aN   (addr[3]),
    .g2bN   (~(ioRd | ioWr)),
    .sel    (addr[SEL_W-1:0]),
    .lineOut(lines)
  );

  always_comb begin
    strobes.ioRd      = ioRd;
    strobes.ioWr      = ioWr;
    strobes.portSel   = lines;
    strobes.laneEn[0] = ~addr[0];
    strobes.laneEn[1] = ~bheN;
  end
endmodule

// File: rtl/ioPortDatapath.sv
module ioPortDatapath
  import ioPortPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  portStrobeT                  strobes,
  input  logic [WORD_W-1:0]           dataIn,
  input  logic [NUM_PORTS*WORD_W-1:0] portIn,
  output logic [NUM_PORTS*WORD_W-1:0] portOut,
  output logic [WORD_W-1:0]           rdData,
  output logic [LANES-1:0]            rdOe
);
  logic hit;
  logic [WORD_W-1:0] muxWord;

  assign hit = |strobes.portSel;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          portOut[p*WORD_W + l*BYTE_W +: BYTE_W] <= '0;
        else if (strobes.ioWr && strobes.portSel[p] && strobes.laneEn[l])
          portOut[p*WORD_W + l*BYTE_W +: BYTE_W] <= dataIn[l*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    muxWord = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (strobes.portSel[p]) muxWord |= portIn[p*WORD_W +: WORD_W];
  end

  assign rdOe = {LANES{strobes.ioRd & hit}} & strobes.laneEn;

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rdData[l*BYTE_W +: BYTE_W] = rdOe[l] ? muxWord[l*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/ioDecodedPort.sv
module ioDecodedPort
  import ioPortPkg::*;
#(
  parameter logic [7:0] HI_MATCH = 8'h00
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdN,
  input  logic          wrN,
  input  logic          memIoN,
  input  logic [15:0]   addr,
  input  logic          bheN,
  input  logic [15:0]   dataIn,
  output logic [15:0]   rdData,
  output logic [1:0]    rdOe,
  input  logic [127:0]  portIn,
  output logic [127:0]  portOut
);
  portStrobeT strobes;

  ioPortCtrl #(.HI_MATCH(HI_MATCH)) i_ctrl (
    .rdN(rdN), .wrN(wrN), .memIoN(memIoN), .addr(addr), .bheN(bheN),
    .strobes(strobes)
  );

  ioPortDatapath i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .portIn(portIn), .portOut(portOut), .rdData(rdData), .rdOe(rdOe)
  );
endmodule

// File: rtl/ioDecodedPortChk.sv
module ioDecodedPortChk #(
  parameter logic [7:0] HI_MATCH = 8'h00
) (
  input logic         clk,
  input logic         rstN,
  input logic         rdN,
  input logic         wrN,
  input logic         memIoN,
  input logic [15:0]  addr,
  input logic         bheN,
  input logic [1:0]   rdOe,
  input logic [15:0]  rdData,
  input logic [127:0] portOut
);
  a_r1_mem_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    memIoN |-> rdOe == 2'b00);

  a_r2_miss_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (addr[15:8] != HI_MATCH || addr[7:3] != 5'b11110) |-> rdOe == 2'b00);

  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrN || memIoN) |=> $stable(portOut));

  a_r5_illegal_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (bheN && addr[0]) |-> rdOe == 2'b00);

  a_r6_drive_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdOe != 2'b00) |-> (!rdN && !memIoN));

  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (rdOe == 2'b00) |-> rdData == 16'h0000);
endmodule

bind ioDecodedPort ioDecodedPortChk #(.HI_MATCH(HI_MATCH)) i_chk (
  .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN), .memIoN(memIoN),
  .addr(addr), .bheN(bheN), .rdOe(rdOe), .rdData(rdData), .portOut(portOut)
);

// File: tb/test_ioDecodedPort.sv
module test_ioDecodedPort;
  logic clk = 0, rstN = 0, rdN = 1, wrN = 1, memIoN = 1, bheN = 1;
  logic [15:0] addr = 0, dataIn = 0;
  logic [15:0] rdData;
  logic [1:0] rdOe;
  logic [127:0] portIn = 0, portOut;
  logic [15:0] expOut [8];
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ioDecodedPort i_ioDecodedPort (
    .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN), .memIoN(memIoN),
    .addr(addr), .bheN(bheN), .dataIn(dataIn), .rdData(rdData),
    .rdOe(rdOe), .portIn(portIn), .portOut(portOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkLatches(string req);
    for (int p = 0; p < 8; p++) check(req, {16'h0, portOut[p*16 +: 16]}, {16'h0, expOut[p]});
  endtask

  task automatic busWrite(logic mem, logic [15:0] a, logic bhe, logic [15:0] d);
    @(negedge clk);
    memIoN = mem; addr = a; bheN = bhe; dataIn = d; wrN = 0;
    @(negedge clk);
    wrN = 1; memIoN = 1; dataIn = 16'hDEAD;
    @(negedge clk);
  endtask

  task automatic busRead(logic mem, logic [15:0] a, logic bhe, string req,
                         logic [1:0] expOe, logic [15:0] expData);
    @(negedge clk);
    memIoN = mem; addr = a; bheN = bhe; rdN = 0;
    #1;
    check(req, {30'h0, rdOe}, {30'h0, expOe});
    check(req, {16'h0, rdData}, {16'h0, expData});
    @(negedge clk);
    rdN = 1; memIoN = 1;
    #1;
    check(req, {30'h0, rdOe}, 32'h0);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    for (int p = 0; p < 8; p++) expOut[p] = 16'h0;
  endtask

  task automatic tResetState();
    #1;
    checkLatches("R8 reset state");
    check("R8 idle oe", {30'h0, rdOe}, 32'h0);
  endtask

  task automatic tWordWriteHold();
    busWrite(0, 16'h00F0, 0, 16'h1234);
    expOut[0] = 16'h1234;
    checkLatches("R4 word write");
    repeat (3) @(negedge clk);
    checkLatches("R4 held after strobe");
  endtask

  task automatic tLanes();
    busWrite(0, 16'h00F2, 1, 16'h77AB);
    expOut[2] = 16'h00AB;
    checkLatches("R5 low lane only");
    busWrite(0, 16'h00F3, 0, 16'hCD99);
    expOut[3] = 16'hCD00;
    checkLatches("R5 high lane only");
    busWrite(0, 16'h00F5, 1, 16'hFFFF);
    checkLatches("R5 illegal pattern ignored");
    portIn[5*16 +: 16] = 16'h1111;
    busRead(0, 16'h00F5, 1, "R5 illegal read not driven", 2'b00, 16'h0000);
  endtask

  task automatic tMemoryAndMiss();
    busWrite(1, 16'h00F0, 0, 16'hAAAA);
    checkLatches("R1 memory write ignored");
    busRead(1, 16'h00F0, 0, "R1 memory read not driven", 2'b00, 16'h0000);
    busWrite(0, 16'h01F0, 0, 16'hBBBB);
    checkLatches("R2 upper byte miss");
    busWrite(0, 16'h00E8, 0, 16'hCCCC);
    checkLatches("R2 A3 set miss");
    busRead(0, 16'h00F8, 0, "R2 read miss", 2'b00, 16'h0000);
  endtask

  task automatic tReads();
    portIn[4*16 +: 16] = 16'hBEEF;
    busRead(0, 16'h00F4, 0, "R6 word read", 2'b11, 16'hBEEF);
    busRead(0, 16'h00F4, 1, "R6 low byte read", 2'b01, 16'h00EF);
    portIn[3*16 +: 16] = 16'h5A5A;
    busRead(0, 16'h00F3, 0, "R7 shared number reads input", 2'b10, 16'h5A00);
    checkLatches("R7 read leaves latch");
  endtask

  task automatic tAllPorts();
    for (int p = 0; p < 8; p++) begin
      busWrite(0, 16'h00F0 + 16'(p), 0, 16'h1010 * 16'(p + 1));
      if (p % 2 == 0) expOut[p] = 16'h1010 * 16'(p + 1);
      else expOut[p] = {8'(16'h1010 * 16'(p + 1) >> 8), 8'h00};
      checkLatches("R3 one port per address");
    end
  endtask

  task automatic tResetMidRun();
    doReset();
    #1;
    checkLatches("R8 reset clears latches");
  endtask

  initial begin
    for (int p = 0; p < 8; p++) expOut[p] = 16'h0;
    repeat (2) @(negedge clk);
    rstN = 1;
    tResetState();
    tWordWriteHold();
    tLanes();
    tMemoryAndMiss();
    tReads();
    tAllPorts();
    tResetMidRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule